// File: doc/BRIEF.md
# Differential Biphase Line Encoder

This block turns a serial stream of already-scrambled NRZ bits into line symbols. Each incoming bit is first precoded differentially: it is XORed into a one-bit running state. The result is then mapped onto a bit cell of two half-symbols with a mid-cell transition. The direction of that transition, not a level, carries the precoded bit: a rising edge at mid-cell is a 1 and a falling edge is a 0. Because every cell spends one half at each level, the stream has no DC content and the far end can recover a clock from it.

The block runs on a clock at twice the baud rate, so one clock cycle is one half-cell. A source offers a bit with a valid strobe. The strobe is taken only at a cell boundary. The output is a two-bit code {enable, level}, which keeps the idle bias condition (`00`) apart from the driven logic levels (`10` for low, `11` for high).

Two disable inputs force the output to bias at once. One is a pin and one is a diagnostic control bit. While disabled, the differential state is frozen.

The controller is a three-state machine:
- PH_IDLE: no cell in progress; output at bias.
- PH_FIRST: first half of a cell; the output drives the complement of the precoded bit.
- PH_SECOND: second half of a cell; the output drives the precoded bit.

The transitions are:
- accept: PH_IDLE or PH_SECOND to PH_FIRST, when a valid bit is present at the boundary.
- mid: PH_FIRST to PH_SECOND.
- starve: PH_IDLE or PH_SECOND to PH_IDLE, when no valid bit is present.
- kill: any state to PH_IDLE, while either disable is high.

Top module: `diff_biphase_encoder`

## Requirements
- R1: After reset the output is `00` (bias) and the differential state is 0, so a first bit of 1 produces a cell of `10` followed by `11`.
- R2: On each accepted bit, the new differential state equals the previous state XOR the data bit.
- R3: A cell drives `{1, ~s}` in its first half and `{1, s}` in its second half, where s is the new differential state: a rising mid-cell edge means s=1 and a falling one means s=0.
- R4: Every cell has a level change between its two halves and spends exactly one half-cell at each level.
- R5: A bit is accepted on a clock edge where `data_valid` is high, the block is enabled and the FSM is in PH_IDLE or PH_SECOND. Its first half appears in the next cycle and its second half in the cycle after that.
- R6: `data_valid` is ignored during a first half: it neither starts a cell nor changes the differential state.
- R7: With `data_valid` held high, cells follow back to back with no gap. With no valid bit at a boundary, the output returns to `00`.
- R8: While `out_disable` or `diag_disable` is high, the output is `00` in that same cycle. Any cell in progress is abandoned and the FSM is in PH_IDLE.
- R9: The differential state holds its value while disabled, even if `data_valid` pulses.
- R10: After both disables are released, the next cell starts only when a valid bit is accepted from PH_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the baud rate (one cycle per half-cell) |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 1 | Scrambled NRZ data bit |
| data_valid | input | 1 | Data bit is offered this cycle |
| out_disable | input | 1 | Disable pin: forces bias output |
| diag_disable | input | 1 | Diagnostic control bit: forces bias output |
| line_code | output | 2 | Line symbol {enable, level}; `00` bias, `10` low, `11` high |

## Verification
The assertions check on every cycle that:
- a second half is driven and differs in level from the first half just before it;
- either disable gives bias at once and sends the FSM to idle;
- a first half is always followed by a second half;
- the differential state never moves unless a bit is accepted.

Only the bench's scenarios can show that the transmitted polarities carry the right data. It does this by decoding a stream back to the original bits. The bench scenarios also cover:
- the effect of the reset state on the first cell;
- strobes ignored during a first half;
- the frozen state across a disable window.

// File: rtl/biphase_enc_pkg.sv
package biphase_enc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;

    localparam int          CODE_W    = 2;
    localparam logic [CODE_W-1:0] CODE_BIAS = 2'b00;

endpackage

// File: rtl/dbe_precoder.sv
module dbe_precoder (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    output logic enc_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_q <= 1'b0;
        end else if (load) begin
            enc_q <= enc_q ^ din;
        end
    end

    // R9 / R6: state moves only on an accepted bit
    assert_hold_without_load_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        !load |=> $stable(enc_q)
    );

endmodule

// File: rtl/dbe_phase_fsm.sv
module dbe_phase_fsm
    import biphase_enc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bit_valid,
    input  logic   line_off,
    output phase_e phase_q,
    output logic   load
);

    phase_e phase_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = PH_IDLE;
        load    = 1'b0;
        if (!line_off) begin
            unique case (phase_q)
                PH_FIRST: begin
                    phase_d = PH_SECOND;
                end
                PH_IDLE, PH_SECOND: begin
                    if (bit_valid) begin
                        phase_d = PH_FIRST;
                        load    = 1'b1;
                    end
                end
                default: begin
                    phase_d = PH_IDLE;
                end
            endcase
        end
    end

    // R5: a first half is always followed by its second half
    assert_first_then_second_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FIRST && !line_off) |=> (phase_q == PH_SECOND)
    );

    // R8: a disable abandons the cell
    assert_off_goes_idle_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        line_off |=> (phase_q == PH_IDLE)
    );

endmodule

// File: rtl/dbe_line_map.sv
module dbe_line_map
    import biphase_enc_pkg::*;
(
    input  phase_e            phase,
    input  logic              enc,
    input  logic              line_off,
    output logic [CODE_W-1:0] line_code
);

    always_comb begin
        line_code = CODE_BIAS;
        if (!line_off) begin
            unique case (phase)
                PH_FIRST:  line_code = {1'b1, ~enc};
                PH_SECOND: line_code = {1'b1, enc};
                default:   line_code = CODE_BIAS;
            endcase
        end
    end

endmodule

// File: rtl/diff_biphase_encoder.sv
module diff_biphase_encoder
    import biphase_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_in,
    input  logic              data_valid,
    input  logic              out_disable,
    input  logic              diag_disable,
    output logic [CODE_W-1:0] line_code
);

    logic   line_off;
    logic   load;
    logic   enc_q;
    phase_e phase_q;

    assign line_off = out_disable | diag_disable;

    dbe_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (data_valid),
        .line_off  (line_off),
        .phase_q   (phase_q),
        .load      (load)
    );

    dbe_precoder u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (data_in),
        .enc_q (enc_q)
    );

    dbe_line_map u_map (
        .phase     (phase_q),
        .enc       (enc_q),
        .line_off  (line_off),
        .line_code (line_code)
    );

    // R4: second half is driven and differs in level from the first half
    assert_mid_transition_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SECOND && !line_off) |->
            (line_code[1] && $past(line_code[1]) &&
             (line_code[0] != $past(line_code[0])))
    );

    // R8: either disable gives bias in the same cycle
    assert_disable_bias_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        line_off |-> (line_code == CODE_BIAS)
    );

    // R3: a first half while enabled is always a driven level
    assert_first_driven_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FIRST && !line_off) |-> line_code[1]
    );

endmodule

// File: tb/diff_biphase_encoder_test.sv
module diff_biphase_encoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_in = 1'b0;
    logic       data_valid = 1'b0;
    logic       out_disable = 1'b0;
    logic       diag_disable = 1'b0;
    logic [1:0] line_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench view of the block: 0 idle, 1 first half, 2 second half
    int   m_phase = 0;
    logic m_enc   = 1'b0;
    logic [1:0] last_got;

    always #5 clk = ~clk;

    diff_biphase_encoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_in      (data_in),
        .data_valid   (data_valid),
        .out_disable  (out_disable),
        .diag_disable (diag_disable),
        .line_code    (line_code)
    );

    function automatic logic [1:0] exp_code(int ph, logic s, logic off);
        if (off || ph == 0) return 2'b00;
        if (ph == 1)        return {1'b1, ~s};
        return {1'b1, s};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(string tag, logic v, logic b, logic d1, logic d2);
        logic off;
        @(negedge clk);
        data_valid   = v;
        data_in      = b;
        out_disable  = d1;
        diag_disable = d2;
        #1;
        off = d1 | d2;
        last_got = line_code;
        check(tag, {30'd0, line_code}, {30'd0, exp_code(m_phase, m_enc, off)});
        @(posedge clk);
        if (off) begin
            m_phase = 0;
        end else if (m_phase == 1) begin
            m_phase = 2;
        end else if (v) begin
            m_enc   = m_enc ^ b;
            m_phase = 1;
        end else begin
            m_phase = 0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] bits;
        logic [1:0] lv [0:16];
        logic       prev;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset bias", {30'd0, line_code}, 32'd0);
        rst_n = 1'b1;

        // R1/R5: first bit 1 from the zero state gives 10 then 11
        step("R5 accept from idle", 1, 1, 0, 0);
        step("R1 first half", 0, 0, 0, 0);
        check("R1 first half 10", {30'd0, last_got}, 32'd2);
        step("R1 second half", 0, 0, 0, 0);
        check("R1 second half 11", {30'd0, last_got}, 32'd3);
        step("R7 gap to bias", 0, 0, 0, 0);
        check("R7 bias after gap", {30'd0, last_got}, 32'd0);

        // R2/R3/R4/R7: back-to-back stream decoded back to data
        bits = 8'b1011_0010;
        prev = m_enc;
        for (int k = 0; k <= 16; k++) begin
            if (k < 16 && (k % 2) == 0)
                step("R7 stream", 1, bits[k/2], 0, 0);
            else
                step("R7 stream", 0, 0, 0, 0);
            lv[k] = last_got;
        end
        for (int i = 0; i < 8; i++) begin
            check("R4 mid-cell change",
                  {31'd0, lv[2*i+1][0] ^ lv[2*i+2][0]}, 32'd1);
            check("R3 halves driven",
                  {30'd0, lv[2*i+1][1], lv[2*i+2][1]}, 32'd3);
            check("R2 decoded data",
                  {31'd0, lv[2*i+2][0] ^ prev}, {31'd0, bits[i]});
            prev = lv[2*i+2][0];
        end

        // R6: strobe in a first half is ignored
        step("R6 accept", 1, 0, 0, 0);
        step("R6 strobe first half", 1, 1, 0, 0);
        step("R6 second half", 0, 0, 0, 0);
        step("R6 idle", 0, 0, 0, 0);
        step("R6 next accept", 1, 1, 0, 0);
        step("R6 state unchanged", 0, 0, 0, 0);
        step("R6 state unchanged", 0, 0, 0, 0);

        // R8/R9/R10: disables abort cells and freeze the state
        step("R8 accept", 1, 1, 0, 0);
        step("R8 pin mid-cell", 0, 0, 1, 0);
        check("R8 pin bias", {30'd0, last_got}, 32'd0);
        step("R9 valid while off", 1, 1, 1, 0);
        step("R9 valid while diag", 1, 1, 0, 1);
        check("R8 diag bias", {30'd0, last_got}, 32'd0);
        step("R10 released idle", 0, 0, 0, 0);
        check("R10 idle after release", {30'd0, last_got}, 32'd0);
        step("R10 accept", 1, 0, 0, 0);
        step("R9 frozen state first", 0, 0, 0, 0);
        step("R9 frozen state second", 0, 0, 0, 0);

        // random mix against the bench model
        for (int c = 0; c < 4000; c++) begin
            logic v, b, d1, d2;
            v  = ($urandom % 4) != 0;
            b  = $urandom % 2;
            d1 = ($urandom % 16) == 0;
            d2 = ($urandom % 20) == 0;
            step("R3 random", v, b, d1, d2);
        end

        finish_run();
    end

endmodule